// File: doc/BRIEF.md
# Routed Interrupt Controller with Idle Wake

The block gathers one level-sensitive request line from each peripheral. Each line is already the OR of that peripheral's own enabled second-level causes. The block brings every line into its clock domain and gates it with a per-source mask. It then sends each surviving request to one of two processor inputs: a normal interrupt line or a fast interrupt line. The choice is made per source by a routing register. Software reads two pending registers to find which device needs attention. It then reads that device's own status.

A register port with word-aligned byte offsets gives access to the mask, the routing and a one-bit control register. The two pending registers are read-only. A request is cleared only by servicing it at the peripheral. While the processor reports that it is idle, the block raises a wake request for the power manager. A control bit decides whether that wake honours the mask or considers every active source.

Top module: `intc_router`

## Requirements
- R1: Source inputs pass through a two-flop synchronizer. A source change becomes visible in the pending registers after the second rising clock edge. It reaches irq_out and fiq_out after the third rising edge.
- R2: The mask register sits at byte offset 0x04. Bit n equal to 1 lets source n interrupt. It resets to all zeros.
- R3: The routing register sits at offset 0x08. Bit n equal to 0 steers source n to the normal line, and bit n equal to 1 steers it to the fast line. It resets to all zeros.
- R4: Reading offset 0x00 returns the normal-line pending set, equal to synchronized sources AND mask AND NOT routing.
- R5: Reading offset 0x10 returns the fast-line pending set, equal to synchronized sources AND mask AND routing.
- R6: irq_out is a registered OR of the normal-line pending set, and fiq_out is a registered OR of the fast-line pending set. The two pending sets never share a bit.
- R7: wake_req is registered and is high only in the cycle after cpu_idle was high. With the control bit at 1, it needs at least one active unmasked source, on either line. With the control bit at 0, any active source wakes, whatever the mask says.
- R8: The control register sits at offset 0x0C. Its only bit is bit 0, the wake-mask-honour bit. The other bits read as zero. It resets to 0.
- R9: Writes to offsets 0x00, 0x10 and any unmapped offset change no register. Reads of unmapped offsets, including unaligned ones, return zero.
- R10: During and right after reset, irq_out, fiq_out and wake_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NUM_SRC | One level request per peripheral, asynchronous |
| cpu_idle | input | 1 | High while the processor is idle, synchronous to clk |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data for reg_addr, combinational |
| irq_out | output | 1 | Normal interrupt to the processor |
| fiq_out | output | 1 | Fast interrupt to the processor |
| wake_req | output | 1 | Resume request to the power manager |

## Verification
The bench builds the block with its defaults: 32 sources and an 8-bit offset. With these values, random masks and routings touch every bit position, including the top source bit. The address range also reaches unmapped offsets above 0x10 and unaligned ones between mapped words. Directed steps count the synchronizer and output-register latency edge by edge. Further steps exercise both settings of the control bit while sources are masked. The remaining steps write to the read-only and unmapped offsets.

// File: rtl/intc_pkg.sv
// intc_pkg: register offsets and control bit position shared by the
// interrupt router modules. Offsets are byte addresses of 32-bit words.
package intc_pkg;
    localparam int unsigned OFS_IRQ_PEND = 32'h00;
    localparam int unsigned OFS_MASK     = 32'h04;
    localparam int unsigned OFS_ROUTE    = 32'h08;
    localparam int unsigned OFS_CTRL     = 32'h0C;
    localparam int unsigned OFS_FIQ_PEND = 32'h10;
    localparam int unsigned CTRL_HONOUR_BIT = 0;
endpackage

// File: rtl/intc_sync.sv
// intc_sync: two-flop synchronizer for a vector of independent level
// requests. Assumes each bit is a slow level, so per-bit skew is harmless.
module intc_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    // Capture and re-time the raw requests, clearing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= din;
            stage2 <= stage1;
        end
    end

    assign dout = stage2;
endmodule

// File: rtl/intc_regs.sv
// intc_regs: writable mask, routing and control registers. Assumes a
// single-cycle write strobe. Writes to any other offset are dropped.
module intc_regs
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] route,
    output logic               honour
);
    logic hit_mask, hit_route, hit_ctrl;

    // Decode which writable register the access targets.
    always_comb begin
        hit_mask  = (reg_addr == ADDR_W'(OFS_MASK));
        hit_route = (reg_addr == ADDR_W'(OFS_ROUTE));
        hit_ctrl  = (reg_addr == ADDR_W'(OFS_CTRL));
    end

    // Update the targeted register on a write, clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            route  <= '0;
            honour <= 1'b0;
        end else if (reg_wr) begin
            if (hit_mask)  mask   <= reg_wdata;
            if (hit_route) route  <= reg_wdata;
            if (hit_ctrl)  honour <= reg_wdata[CTRL_HONOUR_BIT];
        end
    end

    // R9: a write to any offset that is not writable leaves every register unchanged.
    p_ro_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !hit_mask && !hit_route && !hit_ctrl)
        |=> ($stable(mask) && $stable(route) && $stable(honour)));

    // R10: the registers come out of reset cleared.
    p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask == '0 && route == '0 && !honour));
endmodule

// File: rtl/intc_qual.sv
// intc_qual: masks and routes synchronized requests per source, and
// registers the processor lines and the idle wake request.
// Assumes cpu_idle is already synchronous to clk.
module intc_qual #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_sync,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] route,
    input  logic               honour,
    input  logic               cpu_idle,
    output logic [NUM_SRC-1:0] irq_pend,
    output logic [NUM_SRC-1:0] fiq_pend,
    output logic               irq_out,
    output logic               fiq_out,
    output logic               wake_req
);
    logic [NUM_SRC-1:0] wake_cand;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // Qualify one source and steer it to exactly one line.
        always_comb begin
            irq_pend[i]  = src_sync[i] & mask[i] & ~route[i];
            fiq_pend[i]  = src_sync[i] & mask[i] &  route[i];
            wake_cand[i] = src_sync[i] & (mask[i] | ~honour);
        end
    end

    // Register the combined lines so the processor sees clean levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out  <= 1'b0;
            fiq_out  <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            irq_out  <= |irq_pend;
            fiq_out  <= |fiq_pend;
            wake_req <= cpu_idle & (|wake_cand);
        end
    end

    // R6: no source is pending on both lines at once.
    p_route_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend & fiq_pend) == '0);

    // R4: only unmasked sources reach a pending set.
    p_pend_within_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pend | fiq_pend) & ~mask) == '0);

    // R6: with no active source, neither processor line rises next cycle.
    p_lines_need_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sync == '0) |=> (!irq_out && !fiq_out));

    // R7: a wake only follows a cycle in which the processor was idle.
    p_wake_needs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(cpu_idle));
endmodule

// File: rtl/intc_router.sv
// intc_router: top of the routed interrupt controller. Synchronizes the
// source lines, holds the mask, routing and control registers, and
// qualifies requests. Assumes NUM_SRC equals the register data width.
module intc_router
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               cpu_idle,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_out,
    output logic               fiq_out,
    output logic               wake_req
);
    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] route;
    logic               honour;
    logic [NUM_SRC-1:0] irq_pend;
    logic [NUM_SRC-1:0] fiq_pend;

    intc_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (src_req),
        .dout (src_sync)
    );

    intc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .mask     (mask),
        .route    (route),
        .honour   (honour)
    );

    intc_qual #(.NUM_SRC(NUM_SRC)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sync(src_sync),
        .mask    (mask),
        .route   (route),
        .honour  (honour),
        .cpu_idle(cpu_idle),
        .irq_pend(irq_pend),
        .fiq_pend(fiq_pend),
        .irq_out (irq_out),
        .fiq_out (fiq_out),
        .wake_req(wake_req)
    );

    // Select read data by offset, returning zero for unmapped offsets.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_IRQ_PEND))      reg_rdata = irq_pend;
        else if (reg_addr == ADDR_W'(OFS_MASK))     reg_rdata = mask;
        else if (reg_addr == ADDR_W'(OFS_ROUTE))    reg_rdata = route;
        else if (reg_addr == ADDR_W'(OFS_CTRL))     reg_rdata[CTRL_HONOUR_BIT] = honour;
        else if (reg_addr == ADDR_W'(OFS_FIQ_PEND)) reg_rdata = fiq_pend;
    end

    // R10: outputs stay low in the first cycle after reset.
    p_outputs_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_out && !fiq_out && !wake_req));
endmodule

// File: tb/intc_router_tb.sv
// intc_router_tb: directed corner cases plus seeded random register and
// source patterns, checked against bench-computed expected values.
module intc_router_tb;
    localparam int unsigned NS = 32;
    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_req = '0;
    logic          cpu_idle = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [NS-1:0] reg_wdata = '0;
    logic [NS-1:0] reg_rdata;
    logic          irq_out, fiq_out, wake_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    intc_router #(.NUM_SRC(NS), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .cpu_idle(cpu_idle),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .fiq_out(fiq_out),
        .wake_req(wake_req)
    );

    always #4 clk = ~clk;

    function automatic logic [NS-1:0] exp_irq(logic [NS-1:0] s, logic [NS-1:0] m, logic [NS-1:0] l);
        return s & m & ~l;
    endfunction
    function automatic logic [NS-1:0] exp_fiq(logic [NS-1:0] s, logic [NS-1:0] m, logic [NS-1:0] l);
        return s & m & l;
    endfunction
    function automatic logic exp_wake(logic idle, logic h, logic [NS-1:0] s, logic [NS-1:0] m);
        return idle && ((h ? (s & m) : s) != '0);
    endfunction

    task automatic chk(string tag, logic [NS-1:0] act, logic [NS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [NS-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [NS-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NS-1:0] d, m, l, s;
        logic h, idle;
        int unsigned seed_val;
        seed_val = $urandom(32'h5eed_1c01);

        repeat (4) @(negedge clk);
        // R10: outputs low while in reset
        chk("R10 irq in reset", {31'b0, irq_out}, '0);
        chk("R10 wake in reset", {31'b0, wake_req}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h04, d); chk("R2 mask reset", d, '0);
        rd(8'h08, d); chk("R3 route reset", d, '0);
        rd(8'h0C, d); chk("R8 ctrl reset", d, '0);
        chk("R10 fiq after reset", {31'b0, fiq_out}, '0);

        // R1: latency of synchronizer and output register, source 31 to normal line
        wr(8'h04, 32'hFFFF_FFFF);
        reg_addr = 8'h00;
        @(negedge clk);
        src_req = 32'h8000_0000;
        @(negedge clk); rd(8'h00, d); chk("R1 pend after 1 edge", d, '0);
        @(negedge clk); rd(8'h00, d); chk("R1 pend after 2 edges", d, 32'h8000_0000);
        chk("R1 irq after 2 edges", {31'b0, irq_out}, '0);
        @(negedge clk); chk("R1 irq after 3 edges", {31'b0, irq_out}, 32'd1);
        chk("R5 fiq stays low", {31'b0, fiq_out}, '0);

        // R3/R5: reroute source 31 to the fast line
        wr(8'h08, 32'h8000_0000);
        @(negedge clk);
        rd(8'h10, d); chk("R5 fiq pend rerouted", d, 32'h8000_0000);
        rd(8'h00, d); chk("R4 irq pend empty", d, '0);
        chk("R6 fiq line", {31'b0, fiq_out}, 32'd1);
        chk("R6 irq line dropped", {31'b0, irq_out}, '0);

        // R9: writes to read-only and unmapped offsets are dropped
        wr(8'h00, 32'h0000_0000);
        wr(8'h10, 32'h0000_0000);
        wr(8'h14, 32'h0000_0000);
        wr(8'h05, 32'h0000_0000);
        rd(8'h04, d); chk("R9 mask kept", d, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R9 route kept", d, 32'h8000_0000);
        rd(8'h10, d); chk("R9 fiq pend kept", d, 32'h8000_0000);
        rd(8'h14, d); chk("R9 unmapped read", d, '0);
        rd(8'h05, d); chk("R9 unaligned read", d, '0);

        // R8: only bit 0 of control is kept
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, d); chk("R8 ctrl readback", d, 32'd1);

        // R7: masked source with honour=1 does not wake, honour=0 does
        wr(8'h04, 32'h0000_0000);
        cpu_idle = 1'b1;
        settle();
        chk("R7 masked no wake honour", {31'b0, wake_req}, '0);
        chk("R2 masked no irq", {31'b0, irq_out | fiq_out}, '0);
        wr(8'h0C, 32'h0);
        @(negedge clk);
        chk("R7 masked wake mask ignored", {31'b0, wake_req}, 32'd1);
        cpu_idle = 1'b0;
        @(negedge clk);
        chk("R7 no wake when busy", {31'b0, wake_req}, '0);

        // Random patterns over every requirement's data path
        for (int it = 0; it < 300; it++) begin
            m = $urandom; l = $urandom; h = $urandom_range(0, 1);
            s = (it % 3 == 0) ? ($urandom & $urandom & $urandom) : $urandom;
            idle = $urandom_range(0, 1);
            if (it % 17 == 0) m = '0;
            if (it % 19 == 0) s = '0;
            wr(8'h04, m); wr(8'h08, l); wr(8'h0C, {31'b0, h});
            src_req = s; cpu_idle = idle;
            settle();
            rd(8'h00, d); chk("R4 irq pend", d, exp_irq(s, m, l));
            rd(8'h10, d); chk("R5 fiq pend", d, exp_fiq(s, m, l));
            chk("R6 irq line", {31'b0, irq_out}, {31'b0, exp_irq(s, m, l) != '0});
            chk("R6 fiq line", {31'b0, fiq_out}, {31'b0, exp_fiq(s, m, l) != '0});
            chk("R7 wake", {31'b0, wake_req}, {31'b0, exp_wake(idle, h, s, m)});
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule